// File: doc/BRIEF.md
# Configuration File Header Stripper

This block sits on a byte stream that carries a device configuration file and removes the file's header, so that only the configuration payload travels downstream. It first drops a fixed-length prefix. It then walks over a fixed number of length-prefixed text fields, using each field's length byte to jump to the next one. Finally it scans byte by byte for a run of four 0xFF sync bytes. The sync run is the first part of the payload and is forwarded along with everything that follows it, up to the end of the file.

Input and output are valid/ready byte streams, and each carries an end-of-file marker. Once the sync run is found, the block reports where the payload starts, as a zero-based count of input bytes. If the file ends before any sync run appears, an error flag rises and nothing is forwarded. After a reset, the block is ready for a file. A one-cycle `start` pulse re-arms it for the next file and abandons any file in progress.

Top module: `cfg_hdr_strip`

## Requirements
- R1: After reset or a `start` pulse, `in_ready` is 1 and `out_valid`, `pay_ofs_vld` and `hdr_err` are 0.
- R2: Input bytes at offsets 0 to 14 are consumed and discarded. The byte at offset 15 is taken as the first field's length byte.
- R3: Exactly four fields are walked. When a length byte L sits at offset p, the next length byte is at p+L+3. No header byte, including 0xFF bytes inside the header, ever appears on the output.
- R4: The search for the sync run begins at offset p4+L4+3, where p4 and L4 are the fourth field's length-byte offset and value. The run is the first four consecutive 0xFF bytes found from that offset onward.
- R5: During the search, any byte other than 0xFF resets the run. Any 0xFF bytes seen before it are dropped and are never forwarded.
- R6: The output carries the four 0xFF sync bytes first. It then carries every later input byte, in order, up to the end of the file. `out_last` is 1 only on the copy of the input byte marked `in_last`.
- R7: `pay_ofs` equals the zero-based input offset of the first byte of the sync run. `pay_ofs_vld` rises in the cycle after the fourth sync byte is accepted. `pay_ofs_vld` and `pay_ofs` then hold until the block is re-armed.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold. While sync bytes are being emitted, and whenever `out_ready` is 0 during forwarding, `in_ready` is 0.
- R9: If a byte marked `in_last` is accepted before the sync run completes, `hdr_err` is 1 from the next cycle, `in_ready` is 0, and `out_valid` never rises until re-arm.
- R10: A `start` pulse in any state, including mid-file, after an error, or after a finished file, returns the block to the R1 state. The next file is then parsed from offset 0.
- R11: If the fourth sync byte is itself marked `in_last`, the four sync bytes are still emitted and `out_last` is 1 on the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that re-arms the block for a new file |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Input byte accepted when high together with `in_valid` |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Input byte is the final byte of the file |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Output byte is the final byte of the file |
| pay_ofs | output | 32 | Input offset of the first payload byte |
| pay_ofs_vld | output | 1 | `pay_ofs` is meaningful |
| hdr_err | output | 1 | File ended before a sync run was found |

## Verification
`pay_ofs_vld` and `hdr_err` each come from a register. Both change one cycle after the deciding input byte is accepted, and the first 0xFF sync byte appears on the output in that same cycle. During forwarding, `in_ready`, `out_valid` and `out_data` follow the inputs within the same cycle. The bench therefore changes inputs just after a rising edge. It evaluates handshakes and outputs at the falling edge that comes before the edge where they take effect. Status flags are read one falling edge after the last byte of a step has been accepted.

// File: rtl/cfg_hdr_strip_pkg.sv
package cfg_hdr_strip_pkg;

    // byte value that forms the sync run ahead of the payload
    localparam logic [7:0] SYNC_BYTE = 8'hFF;

    typedef enum logic [2:0] {
        ST_PARSE = 3'd0,   // walking header fields or hunting for sync run
        ST_FLUSH = 3'd1,   // replaying the held sync bytes downstream
        ST_PASS  = 3'd2,   // forwarding payload bytes straight through
        ST_DONE  = 3'd3,   // end of file forwarded, idle until re-armed
        ST_FAIL  = 3'd4    // file ended without a sync run
    } strip_state_e;

endpackage

// File: rtl/hdr_field_walker.sv
module hdr_field_walker #(
    parameter int HDR_OFS = 15,
    parameter int NFIELDS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       step,
    input  logic [7:0] data,
    output logic       hunt
);
    localparam int OFS_BITS = (HDR_OFS > 0) ? $clog2(HDR_OFS + 1) : 1;
    localparam int GAP_W    = (OFS_BITS > 9) ? OFS_BITS : 9;
    localparam int FLD_W    = $clog2(NFIELDS + 1);

    typedef struct packed {
        logic [GAP_W-1:0] gap;   // bytes still to drop before next length byte
        logic [FLD_W-1:0] fld;   // length bytes consumed so far
    } walk_t;

    walk_t w_d, w_q;

    assign hunt = (w_q.gap == '0) && (w_q.fld == FLD_W'(NFIELDS));

    always_comb begin
        w_d = w_q;
        if (clr) begin
            w_d.gap = GAP_W'(HDR_OFS);
            w_d.fld = '0;
        end else if (step && !hunt) begin
            if (w_q.gap != '0) begin
                w_d.gap = w_q.gap - GAP_W'(1);
            end else begin
                w_d.fld = w_q.fld + FLD_W'(1);
                w_d.gap = GAP_W'(data) + GAP_W'(2);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q.gap <= GAP_W'(HDR_OFS);
            w_q.fld <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    // R4
    hunt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hunt && !clr |=> hunt);

    // R3
    fld_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        w_q.fld <= FLD_W'(NFIELDS));

endmodule

// File: rtl/sync_run_matcher.sv
module sync_run_matcher #(
    parameter int RUN_LEN = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       step,
    input  logic [7:0] data,
    output logic       hit
);
    import cfg_hdr_strip_pkg::*;

    localparam int CNT_W = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;

    logic [CNT_W-1:0] run_d, run_q;
    logic             is_sync;

    assign is_sync = (data == SYNC_BYTE);
    assign hit     = step && is_sync && (run_q == CNT_W'(RUN_LEN - 1));

    always_comb begin
        run_d = run_q;
        if (clr || hit) begin
            run_d = '0;
        end else if (step) begin
            run_d = is_sync ? run_q + CNT_W'(1) : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    // R5
    run_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step && !is_sync |=> run_q == '0);

endmodule

// File: rtl/cfg_hdr_strip.sv
module cfg_hdr_strip #(
    parameter int HDR_OFS = 15,
    parameter int NFIELDS = 4,
    parameter int RUN_LEN = 4,
    parameter int OFS_W   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_data,
    output logic             out_last,
    output logic [OFS_W-1:0] pay_ofs,
    output logic             pay_ofs_vld,
    output logic             hdr_err
);
    import cfg_hdr_strip_pkg::*;

    localparam int FL_W = $clog2(RUN_LEN + 1);

    typedef struct packed {
        strip_state_e     st;
        logic [OFS_W-1:0] pos;        // offset of the next input byte
        logic [OFS_W-1:0] ofs;        // payload start offset
        logic             ofs_vld;
        logic [FL_W-1:0]  left;       // sync bytes still to emit
        logic             last_pend;  // final sync byte ends the file
    } ctl_t;

    ctl_t c_d, c_q;

    logic acc, parse_step, hunt, hit;

    assign in_ready = !start && ((c_q.st == ST_PARSE) ||
                                 ((c_q.st == ST_PASS) && out_ready));
    assign acc        = in_valid && in_ready;
    assign parse_step = acc && (c_q.st == ST_PARSE);

    hdr_field_walker #(.HDR_OFS(HDR_OFS), .NFIELDS(NFIELDS)) u_walk (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start),
        .step  (parse_step),
        .data  (in_data),
        .hunt  (hunt)
    );

    sync_run_matcher #(.RUN_LEN(RUN_LEN)) u_match (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start),
        .step  (parse_step && hunt),
        .data  (in_data),
        .hit   (hit)
    );

    assign out_valid   = !start && ((c_q.st == ST_FLUSH) ||
                                    ((c_q.st == ST_PASS) && in_valid));
    assign out_data    = (c_q.st == ST_FLUSH) ? SYNC_BYTE : in_data;
    assign out_last    = (c_q.st == ST_FLUSH) ?
                         (c_q.last_pend && (c_q.left == FL_W'(1))) : in_last;
    assign pay_ofs     = c_q.ofs;
    assign pay_ofs_vld = c_q.ofs_vld;
    assign hdr_err     = (c_q.st == ST_FAIL);

    always_comb begin
        c_d = c_q;
        if (start) begin
            c_d.st        = ST_PARSE;
            c_d.pos       = '0;
            c_d.ofs       = '0;
            c_d.ofs_vld   = 1'b0;
            c_d.left      = '0;
            c_d.last_pend = 1'b0;
        end else begin
            unique case (c_q.st)
                ST_PARSE: begin
                    if (acc) begin
                        c_d.pos = c_q.pos + OFS_W'(1);
                        if (hit) begin
                            c_d.st        = ST_FLUSH;
                            c_d.ofs       = c_q.pos - OFS_W'(RUN_LEN - 1);
                            c_d.ofs_vld   = 1'b1;
                            c_d.left      = FL_W'(RUN_LEN);
                            c_d.last_pend = in_last;
                        end else if (in_last) begin
                            c_d.st = ST_FAIL;
                        end
                    end
                end
                ST_FLUSH: begin
                    if (out_ready) begin
                        c_d.left = c_q.left - FL_W'(1);
                        if (c_q.left == FL_W'(1)) begin
                            c_d.st = c_q.last_pend ? ST_DONE : ST_PASS;
                        end
                    end
                end
                ST_PASS: begin
                    if (acc) begin
                        c_d.pos = c_q.pos + OFS_W'(1);
                        if (in_last) c_d.st = ST_DONE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.st        <= ST_PARSE;
            c_q.pos       <= '0;
            c_q.ofs       <= '0;
            c_q.ofs_vld   <= 1'b0;
            c_q.left      <= '0;
            c_q.last_pend <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready && !start |=> out_valid && $stable(out_data));

    // R9
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_err |-> !out_valid && !in_ready);

    // R7
    ofs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pay_ofs_vld && !start |=> pay_ofs_vld && $stable(pay_ofs));

    // R6
    first_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pay_ofs_vld) && !start |-> out_valid && out_data == SYNC_BYTE);

    // R3
    no_early_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pay_ofs_vld |-> !out_valid);

endmodule

// File: tb/sim_cfg_hdr_strip.sv
module sim_cfg_hdr_strip;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = 8'h00;
    logic        in_last = 1'b0;
    logic        out_valid;
    logic        out_ready;
    logic [7:0]  out_data;
    logic        out_last;
    logic [31:0] pay_ofs;
    logic        pay_ofs_vld;
    logic        hdr_err;

    always #5 clk = ~clk;

    cfg_hdr_strip u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
        .pay_ofs(pay_ofs), .pay_ofs_vld(pay_ofs_vld), .hdr_err(hdr_err)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    logic [7:0] fbuf  [0:2047];
    logic [7:0] mon_d [0:2047];
    logic       mon_l [0:2047];
    int  flen, exp_ofs, mon_n, ov_n;
    logic mon_clr = 1'b0;
    int  rdy_mode = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        #1;
        case (rdy_mode)
            0:       out_ready <= 1'b1;
            1:       out_ready <= (cyc % 3 != 0);
            default: out_ready <= 1'b0;
        endcase
    end

    always @(negedge clk) begin
        if (mon_clr) begin
            mon_n = 0;
            ov_n  = 0;
        end else if (rst_n) begin
            if (out_valid) ov_n++;
            if (out_valid && out_ready && !start) begin
                if (mon_n < 2048) begin
                    mon_d[mon_n] = out_data;
                    mon_l[mon_n] = out_last;
                end
                mon_n++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(posedge clk); #1;
        mon_clr = 1'b1;
        @(posedge clk); #1;
        mon_clr = 1'b0;
    endtask

    task automatic pulse_start();
        @(posedge clk); #1;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    // header: 15 prefix bytes, four fields (length L then L+2 filler), all filler 0xFF
    task automatic build(input int l0, input int l1, input int l2, input int l3,
                         input int junk, input int pay);
        int ls [4];
        int p;
        int s;
        ls[0] = l0; ls[1] = l1; ls[2] = l2; ls[3] = l3;
        p = 0;
        for (int i = 0; i < 15; i++) begin fbuf[p] = 8'hFF; p++; end
        for (int k = 0; k < 4; k++) begin
            fbuf[p] = 8'(ls[k]); p++;
            for (int i = 0; i < ls[k] + 2; i++) begin fbuf[p] = 8'hFF; p++; end
        end
        s = p;
        for (int i = 0; i < junk; i++) begin
            fbuf[p] = (i % 4 == 3) ? 8'h00 : 8'hFF; p++;
        end
        for (int i = 0; i < 4; i++) begin fbuf[p] = 8'hFF; p++; end
        for (int j = 0; j < pay; j++) begin fbuf[p] = 8'(j * 37 + 11); p++; end
        flen = p;
        exp_ofs = -1;
        for (int i = s; i + 3 < flen; i++) begin
            if (exp_ofs < 0 && fbuf[i] == 8'hFF && fbuf[i+1] == 8'hFF &&
                fbuf[i+2] == 8'hFF && fbuf[i+3] == 8'hFF) exp_ofs = i;
        end
    endtask

    // sends bytes 0..nb-1; in_last only on byte flen-1
    task automatic drive_file(input bit gaps, input int nb);
        int  i;
        int  k;
        bit  acc;
        i = 0; k = 0;
        in_data  = fbuf[0];
        in_last  = (flen == 1);
        in_valid = (nb > 0);
        while (i < nb) begin
            @(negedge clk);
            acc = in_valid && in_ready;
            @(posedge clk); #1;
            if (acc) begin
                i++; k++;
                if (i < nb) begin
                    in_data  = fbuf[i];
                    in_last  = (i == flen - 1);
                    in_valid = !(gaps && (k % 5 == 2));
                end else begin
                    in_valid = 1'b0;
                    in_last  = 1'b0;
                end
            end else if (!in_valid) begin
                in_valid = 1'b1;
            end
        end
    endtask

    task automatic wait_out(input int n);
        for (int t = 0; t < 200 && mon_n < n; t++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_payload(input string req);
        int nexp;
        int bad;
        int lastpos;
        nexp = flen - exp_ofs;
        chk(mon_n == nexp, req, "forwarded byte count", mon_n, nexp);
        bad = 0; lastpos = -1;
        for (int i = 0; i < nexp && i < mon_n; i++) begin
            if (mon_d[i] != fbuf[exp_ofs + i]) bad++;
            if (mon_l[i]) lastpos = i;
        end
        chk(bad == 0, req, "payload byte mismatches", bad, 0);
        chk(lastpos == nexp - 1, req, "out_last position", lastpos, nexp - 1);
        chk(pay_ofs_vld == 1'b1, "R7", "pay_ofs_vld", pay_ofs_vld, 1);
        chk(pay_ofs == 32'(exp_ofs), "R7", "pay_ofs", pay_ofs, exp_ofs);
        chk(hdr_err == 1'b0, "R9", "no error on good file", hdr_err, 0);
    endtask

    typedef struct packed {
        logic [7:0] l0, l1, l2, l3;
        logic [7:0] junk;
        logic [7:0] pay;
        logic [1:0] mode;   // bit0 throttled out_ready, bit1 input gaps
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{8'd0,   8'd0,   8'd0, 8'd0, 8'd0, 8'd8,  2'd0},
        '{8'd5,   8'd1,   8'd9, 8'd2, 8'd3, 8'd20, 2'd1},
        '{8'd12,  8'd0,   8'd3, 8'd7, 8'd6, 8'd16, 2'd2},
        '{8'd255, 8'd200, 8'd1, 8'd4, 8'd9, 8'd12, 2'd3},
        '{8'd3,   8'd3,   8'd3, 8'd3, 8'd4, 8'd0,  2'd1}
    };

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        chk(pay_ofs_vld == 1'b0, "R1", "pay_ofs_vld after reset", pay_ofs_vld, 0);
        chk(hdr_err == 1'b0, "R1", "hdr_err after reset", hdr_err, 0);

        // table walk: R2 R3 R4 R5 R6 R7 R8 R11
        for (int v = 0; v < NV; v++) begin
            rdy_mode = VECS[v].mode[0] ? 1 : 0;
            pulse_start();
            clear_mon();
            build(int'(VECS[v].l0), int'(VECS[v].l1), int'(VECS[v].l2),
                  int'(VECS[v].l3), int'(VECS[v].junk), int'(VECS[v].pay));
            drive_file(VECS[v].mode[1], flen);
            wait_out(flen - exp_ofs);
            check_payload("R2 R3 R4 R5 R6 R8 R11");
        end
        rdy_mode = 0;

        // R10: start after a finished file clears status
        pulse_start();
        @(negedge clk);
        chk(pay_ofs_vld == 1'b0, "R10", "pay_ofs_vld after start", pay_ofs_vld, 0);
        chk(in_ready == 1'b1, "R10", "in_ready after start", in_ready, 1);

        // R9: file ends inside a partial sync run
        clear_mon();
        build(0, 0, 0, 0, 0, 0);
        flen = 27 + 3;
        drive_file(1'b0, flen);
        @(negedge clk);
        chk(hdr_err == 1'b1, "R9", "hdr_err after early end", hdr_err, 1);
        chk(in_ready == 1'b0, "R9", "in_ready in error", in_ready, 0);
        chk(ov_n == 0, "R9", "out_valid cycles", ov_n, 0);
        chk(pay_ofs_vld == 1'b0, "R9", "pay_ofs_vld in error", pay_ofs_vld, 0);

        // R10: start clears error
        pulse_start();
        @(negedge clk);
        chk(hdr_err == 1'b0, "R10", "hdr_err after start", hdr_err, 0);

        // R10: abort mid-file, then a full file parses from offset 0
        build(2, 2, 2, 2, 0, 5);
        drive_file(1'b0, 20);
        pulse_start();
        @(negedge clk);
        chk(in_ready == 1'b1 && pay_ofs_vld == 1'b0 && hdr_err == 1'b0,
            "R10", "re-armed mid-file", {in_ready, pay_ofs_vld, hdr_err}, 3'b100);
        clear_mon();
        drive_file(1'b1, flen);
        wait_out(flen - exp_ofs);
        check_payload("R10");

        // R8: downstream blocked while sync bytes are pending
        rdy_mode = 2;
        pulse_start();
        clear_mon();
        build(1, 1, 1, 1, 0, 4);
        fork
            drive_file(1'b0, flen);
        join_none
        for (int t = 0; t < 200 && !pay_ofs_vld; t++) @(negedge clk);
        for (int t = 0; t < 3; t++) begin
            @(negedge clk);
            chk(out_valid == 1'b1 && out_data == 8'hFF, "R8", "held sync byte",
                {out_valid, out_data}, 9'h1FF);
            chk(in_ready == 1'b0, "R8", "in_ready while flushing", in_ready, 0);
        end
        chk(mon_n == 0, "R8", "nothing taken while blocked", mon_n, 0);
        rdy_mode = 0;
        wait fork;
        wait_out(flen - exp_ofs);
        check_payload("R8");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule